// File: doc/BRIEF.md
# Vector Type Legality Checker

This block inspects a requested vector configuration, made of an element width code, a register grouping code and the index of a destination register, and decides whether the configuration can be used on this build. It raises an illegal flag for configurations that the hardware cannot support, a separate flag when the chosen destination register cannot start a register group of the requested size, and for legal settings it reports the maximum number of elements one instruction can process (VLMAX).

The element width limit (ELEN) and the register width (VLEN) are fixed at build time. A second build parameter gives the widest element allowed at a grouping of one register. When that value is below ELEN it tightens the limit that applies to fractional groupings. The result can be taken straight from the logic or through one register stage, chosen by a parameter. Software can probe supported settings by presenting a configuration and reading the illegal flag.

Top module: `vtype_legality_check`

## Requirements
- R1: With `OUT_REG`=1, while `rst_n` is low the outputs read `vill`=1, `misaligned`=0 and `vlmax`=0.
- R2: Element width code `sew_code` values 0, 1, 2, 3 select 8, 16, 32, 64 bits; any code with bit 2 set is reserved and sets `vill`.
- R3: An element width wider than ELEN sets `vill` for every grouping code.
- R4: Grouping code `lmul_code` is a 3-bit signed value: 0, 1, 2, 3 give 1, 2, 4, 8 registers; 7, 6, 5 give 1/2, 1/4, 1/8; code 4 is reserved and sets `vill`.
- R5: With a fractional grouping 1/D, the configuration is legal only when element width × D does not exceed the fractional limit (with ELEN=32: 1/8 is never legal, 1/4 takes only 8 bits, 1/2 takes 8 or 16 bits).
- R6: The fractional limit is the smaller of ELEN and `SEW_LMUL1_MAX`; integer groupings are bounded by ELEN alone.
- R7: For a legal integer grouping of N registers, `misaligned` is 1 exactly when `vd_idx` is not a multiple of N (with N=8 only 0, 8, 16, 24 are accepted).
- R8: For a legal fractional grouping, or a grouping of one register, `misaligned` is 0 for every register index.
- R9: For a legal configuration, `vlmax` = VLEN × grouping / element width, always a power of two.
- R10: When `vill` is 1, `vlmax` is 0 and `misaligned` is 0.
- R11: With `OUT_REG`=1 the outputs reflect the inputs present at the previous rising clock edge; with `OUT_REG`=0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sew_code | input | 3 | Requested element width code |
| lmul_code | input | 3 | Requested register grouping code |
| vd_idx | input | IDX_W | Destination register index |
| vill | output | 1 | Configuration not supported |
| misaligned | output | 1 | Destination index cannot start the requested group |
| vlmax | output | VLW | Maximum element count, 0 when illegal |

## Verification
Every combination of the eight width codes, eight grouping codes and all register indices is applied to two builds. One build has a 32-bit element limit with the register stage present, which separates the plain ELEN bound on fractional groupings and exposes any one-cycle lag error. The other has a 64-bit element limit capped to 16 bits at unit grouping with no register, which tells apart a design that applies the cap to fractional groupings only from one that applies it everywhere or nowhere. The register index sweep distinguishes an alignment test on the wrong number of low bits, and the illegal cases show whether VLMAX and the alignment flag are forced to zero.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    typedef struct packed {
        logic       rsvd;
        logic [1:0] expo;
    } sew_dec_t;

    typedef struct packed {
        logic       rsvd;
        logic       frac;
        logic [1:0] mag;
    } lmul_dec_t;

    function automatic sew_dec_t decode_sew(input logic [2:0] code);
        sew_dec_t d;
        d.rsvd = code[2];
        d.expo = code[1:0];
        return d;
    endfunction

    function automatic lmul_dec_t decode_lmul(input logic [2:0] code);
        lmul_dec_t d;
        d.rsvd = (code == 3'b100);
        d.frac = code[2];
        d.mag  = code[2] ? (~code[1:0] + 2'd1) : code[1:0];
        return d;
    endfunction

endpackage

// File: rtl/vtc_field_decode.sv
module vtc_field_decode
    import vtc_pkg::*;
(
    input  logic [2:0] sew_code,
    input  logic [2:0] lmul_code,
    output sew_dec_t   sew_d,
    output lmul_dec_t  lmul_d
);
    always_comb begin
        sew_d  = decode_sew(sew_code);
        lmul_d = decode_lmul(lmul_code);
    end
endmodule

// File: rtl/vtc_legal_check.sv
module vtc_legal_check
    import vtc_pkg::*;
#(
    parameter int ELEN          = 32,
    parameter int SEW_LMUL1_MAX = 64
) (
    input  sew_dec_t  sew_d,
    input  lmul_dec_t lmul_d,
    output logic      legal
);
    localparam int EFF_MAX  = (SEW_LMUL1_MAX < ELEN) ? SEW_LMUL1_MAX : ELEN;
    localparam logic [2:0] ELEN_LOG = 3'($clog2(ELEN) - 3);
    localparam logic [2:0] EFF_LOG  = 3'($clog2(EFF_MAX) - 3);

    logic [2:0] frac_need;
    logic       width_ok;
    logic       frac_ok;

    always_comb begin
        frac_need = {1'b0, sew_d.expo} + {1'b0, lmul_d.mag};
        width_ok  = ({1'b0, sew_d.expo} <= ELEN_LOG);
        frac_ok   = !lmul_d.frac || (frac_need <= EFF_LOG);
        legal     = !sew_d.rsvd && !lmul_d.rsvd && width_ok && frac_ok;
    end
endmodule

// File: rtl/vtc_group_align.sv
module vtc_group_align
    import vtc_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  lmul_dec_t        lmul_d,
    input  logic [IDX_W-1:0] vd_idx,
    input  logic             legal,
    output logic             misaligned
);
    logic [IDX_W-1:0] low_mask;

    for (genvar i = 0; i < IDX_W; i++) begin : g_mask
        if (i < 3) begin : g_live
            assign low_mask[i] = !lmul_d.frac && (lmul_d.mag > 2'(i));
        end else begin : g_dead
            assign low_mask[i] = 1'b0;
        end
    end

    assign misaligned = legal && |(vd_idx & low_mask);
endmodule

// File: rtl/vtc_vlmax_calc.sv
module vtc_vlmax_calc
    import vtc_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int VLW  = 8
) (
    input  sew_dec_t        sew_d,
    input  lmul_dec_t       lmul_d,
    input  logic            legal,
    output logic [VLW-1:0]  vlmax
);
    localparam int VLEN_LOG = $clog2(VLEN);

    logic [7:0] shamt;
    logic [7:0] mag_w;

    always_comb begin
        mag_w = {6'b0, lmul_d.mag};
        shamt = 8'(VLEN_LOG) - 8'd3 - {6'b0, sew_d.expo};
        shamt = lmul_d.frac ? (shamt - mag_w) : (shamt + mag_w);
    end

    for (genvar i = 0; i < VLW; i++) begin : g_onehot
        assign vlmax[i] = legal && (shamt == 8'(i));
    end
endmodule

// File: rtl/vtype_legality_check.sv
module vtype_legality_check
    import vtc_pkg::*;
#(
    parameter int ELEN          = 32,
    parameter int VLEN          = 128,
    parameter int SEW_LMUL1_MAX = 64,
    parameter int NUM_VREGS     = 32,
    parameter bit OUT_REG       = 1'b1,
    parameter int IDX_W         = $clog2(NUM_VREGS),
    parameter int VLW           = $clog2(VLEN) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sew_code,
    input  logic [2:0]       lmul_code,
    input  logic [IDX_W-1:0] vd_idx,
    output logic             vill,
    output logic             misaligned,
    output logic [VLW-1:0]   vlmax
);
    sew_dec_t       sew_d;
    lmul_dec_t      lmul_d;
    logic           legal;
    logic           mis_nxt;
    logic [VLW-1:0] vlmax_nxt;

    vtc_field_decode u_decode (
        .sew_code  (sew_code),
        .lmul_code (lmul_code),
        .sew_d     (sew_d),
        .lmul_d    (lmul_d)
    );

    vtc_legal_check #(
        .ELEN          (ELEN),
        .SEW_LMUL1_MAX (SEW_LMUL1_MAX)
    ) u_legal (
        .sew_d  (sew_d),
        .lmul_d (lmul_d),
        .legal  (legal)
    );

    vtc_group_align #(
        .IDX_W (IDX_W)
    ) u_align (
        .lmul_d     (lmul_d),
        .vd_idx     (vd_idx),
        .legal      (legal),
        .misaligned (mis_nxt)
    );

    vtc_vlmax_calc #(
        .VLEN (VLEN),
        .VLW  (VLW)
    ) u_vlmax (
        .sew_d  (sew_d),
        .lmul_d (lmul_d),
        .legal  (legal),
        .vlmax  (vlmax_nxt)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vill       <= 1'b1;
                misaligned <= 1'b0;
                vlmax      <= '0;
            end else begin
                vill       <= !legal;
                misaligned <= mis_nxt;
                vlmax      <= vlmax_nxt;
            end
        end
    end else begin : g_comb
        assign vill       = !legal;
        assign misaligned = mis_nxt;
        assign vlmax      = vlmax_nxt;
    end
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker #(
    parameter bit OUT_REG = 1'b1,
    parameter int IDX_W   = 5,
    parameter int VLW     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sew_code,
    input logic [2:0]       lmul_code,
    input logic [IDX_W-1:0] vd_idx,
    input logic             vill,
    input logic             misaligned,
    input logic [VLW-1:0]   vlmax
);
    logic seen_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (OUT_REG && seen_rst === 1'b1 && !rst_n) begin
            AST_RESET_STATE: assert (vill && !misaligned && vlmax == '0); // R1
        end
    end

    AST_ILLEGAL_NO_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        vill |-> (vlmax == '0)); // R10
    AST_ILLEGAL_NO_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        vill |-> !misaligned); // R10
    AST_LEGAL_HAS_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        !vill |-> (vlmax != '0)); // R9
    AST_LENGTH_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vlmax)); // R9

    if (OUT_REG) begin : g_seq
        AST_RSVD_SEW: assert property (@(posedge clk) disable iff (!rst_n)
            sew_code[2] |=> vill); // R2
        AST_RSVD_LMUL: assert property (@(posedge clk) disable iff (!rst_n)
            (lmul_code == 3'b100) |=> vill); // R4
        AST_FRAC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            (lmul_code[2] || lmul_code == 3'b000) |=> !misaligned); // R8
        AST_ODD_IDX_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
            (lmul_code == 3'b001 && vd_idx[0]) |=> (vill || misaligned)); // R7
    end else begin : g_now
        AST_RSVD_SEW: assert property (@(posedge clk) disable iff (!rst_n)
            sew_code[2] |-> vill); // R2
        AST_RSVD_LMUL: assert property (@(posedge clk) disable iff (!rst_n)
            (lmul_code == 3'b100) |-> vill); // R4
        AST_FRAC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            (lmul_code[2] || lmul_code == 3'b000) |-> !misaligned); // R8
        AST_ODD_IDX_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
            (lmul_code == 3'b001 && vd_idx[0]) |-> (vill || misaligned)); // R7
    end
endmodule

bind vtype_legality_check vtc_checker #(
    .OUT_REG (OUT_REG),
    .IDX_W   (IDX_W),
    .VLW     (VLW)
) u_vtc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sew_code   (sew_code),
    .lmul_code  (lmul_code),
    .vd_idx     (vd_idx),
    .vill       (vill),
    .misaligned (misaligned),
    .vlmax      (vlmax)
);

// File: tb/vtype_legality_check_tb_top.sv
`timescale 1ns/1ps
module vtype_legality_check_tb_top;
    logic       clk;
    logic       rst_n;
    logic [2:0] sew_code;
    logic [2:0] lmul_code;
    logic [4:0] vd_idx;

    logic       a_vill, a_mis;
    logic [7:0] a_vlmax;
    logic       b_vill, b_mis;
    logic [8:0] b_vlmax;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Build A: ELEN 32, VLEN 128, registered
    vtype_legality_check #(
        .ELEN(32), .VLEN(128), .SEW_LMUL1_MAX(64), .NUM_VREGS(32), .OUT_REG(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sew_code(sew_code), .lmul_code(lmul_code),
        .vd_idx(vd_idx), .vill(a_vill), .misaligned(a_mis), .vlmax(a_vlmax)
    );

    // Build B: ELEN 64 capped to 16 at unit grouping, VLEN 256, unregistered
    vtype_legality_check #(
        .ELEN(64), .VLEN(256), .SEW_LMUL1_MAX(16), .NUM_VREGS(32), .OUT_REG(1'b0)
    ) dut_cap_i (
        .clk(clk), .rst_n(rst_n), .sew_code(sew_code), .lmul_code(lmul_code),
        .vd_idx(vd_idx), .vill(b_vill), .misaligned(b_mis), .vlmax(b_vlmax)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d (sew=%0d lmul=%0d idx=%0d)",
                     tag, what, act, exp, sew_code, lmul_code, vd_idx);
        end
    endtask

    task automatic model(input int elen, input int s1max, input int vlen, input bit capped,
                         output bit ill, output bit mis, output int vlm,
                         output string tv, output string tm, output string tl);
        int sewb, num, den, eff;
        bit frac, legal;
        frac = lmul_code[2];
        sewb = 8 << sew_code[1:0];
        num  = frac ? 1 : (1 << lmul_code[1:0]);
        den  = frac ? (1 << (8 - int'(lmul_code))) : 1;
        eff  = (s1max < elen) ? s1max : elen;
        legal = !sew_code[2] && (lmul_code != 3'b100) && (sewb <= elen) &&
                (!frac || (sewb * den <= eff));
        ill = !legal;
        vlm = legal ? (vlen * num) / (sewb * den) : 0;
        mis = legal && !frac && ((int'(vd_idx) % num) != 0);
        if (sew_code[2])             tv = "R2";
        else if (lmul_code == 3'b100) tv = "R4";
        else if (sewb > elen)        tv = "R3";
        else if (frac)               tv = capped ? "R6" : "R5";
        else                         tv = "R6";
        tl = ill ? "R10" : "R9";
        if (ill)                     tm = "R10";
        else if (frac || num == 1)   tm = "R8";
        else                         tm = "R7";
    endtask

    task automatic check_both();
        bit ill, mis; int vlm; string tv, tm, tl;
        model(32, 64, 128, 1'b0, ill, mis, vlm, tv, tm, tl);
        check(tv, a_vill, ill, "A vill");
        check(tm, a_mis, mis, "A misaligned");
        check(tl, a_vlmax, vlm, "A vlmax");
        model(64, 16, 256, 1'b1, ill, mis, vlm, tv, tm, tl);
        check(tv, b_vill, ill, "B vill");
        check(tm, b_mis, mis, "B misaligned");
        check(tl, b_vlmax, vlm, "B vlmax");
    endtask

    initial begin
        rst_n = 1'b0;
        sew_code = 3'd0; lmul_code = 3'd0; vd_idx = 5'd3;
        repeat (3) @(posedge clk);
        #1;
        // R1: registered build holds reset values despite a legal input
        check("R1", a_vill, 1, "reset vill");
        check("R1", a_mis, 0, "reset misaligned");
        check("R1", a_vlmax, 0, "reset vlmax");
        @(negedge clk);
        rst_n = 1'b1;

        for (int s = 0; s < 8; s++) begin
            for (int l = 0; l < 8; l++) begin
                for (int i = 0; i < 32; i++) begin
                    @(negedge clk);
                    sew_code = 3'(s); lmul_code = 3'(l); vd_idx = 5'(i);
                    @(posedge clk);
                    #1;
                    check_both();
                end
            end
        end

        // R11: latency of the two output variants
        @(negedge clk);
        sew_code = 3'd0; lmul_code = 3'b100; vd_idx = 5'd0;
        @(posedge clk);
        @(negedge clk);
        sew_code = 3'd0; lmul_code = 3'd0;
        #1;
        check("R11", a_vill, 1, "registered output before edge");
        check("R11", b_vill, 0, "unregistered output same cycle");
        check("R11", b_vlmax, 32, "unregistered vlmax same cycle");
        @(posedge clk);
        #1;
        check("R11", a_vill, 0, "registered output after edge");
        check("R11", a_vlmax, 16, "registered vlmax after edge");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule